// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves 8-bit frames over a three-wire synchronous link made of a serial clock, a data input and a data output. As clock master it produces the serial clock from the system clock through a programmable divider. As slave it follows a clock driven from outside, after passing that clock through a synchronizer. Incoming bits are sampled on each rising serial clock edge and collected least significant bit first. Outgoing bits change on each falling edge, also least significant bit first. Because both directions share one clock, a byte can go out while another comes in.

A finished incoming byte moves to a holding register only when that register is empty, and the move sets a full flag. If a byte finishes while the holding register is still full, the byte is dropped and an overrun flag is set. While the overrun flag is set, all shifting in both directions stops until the host clears it. Two interrupt request lines report a newly filled holding register and a new overrun. A small four-address register port gives the host the data, the flags, the configuration and the divider value.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Incoming bits are sampled on rising serial clock edges, and the first bit of a frame lands in bit 0 of the received byte. Eight bits make a frame. Register address 0 reads the received byte.
- R2: In master mode (control bit 0 = 1) `sck_oe` is 1, and the serial clock rests high between frames. Each half period of the serial clock lasts divider+1 system clocks, where the divider is register address 3. In slave mode `sck_oe` is 0.
- R3: In slave mode (control bit 0 = 0), frames are clocked by `sck_in`. Reception needs control bit 1 = 1.
- R4: A completed byte goes to the received-byte register only when the full flag (status address 1, bit 0) is 0, and the move sets that flag.
- R5: A byte completed while the full flag is 1 sets the overrun flag (status bit 1). The received-byte register keeps its old value.
- R6: With interrupt enable (control bit 3) set, `irq_rx` goes to 1 when the full flag changes from 0 to 1. With the enable clear, `irq_rx` stays 0.
- R7: With interrupt enable set, `irq_err` goes to 1 when the overrun flag changes from 0 to 1. It returns to 0 when the overrun flag is cleared.
- R8: While the overrun flag is 1, serial clock edges are ignored. No byte is received, no pending transmit byte is loaded, and `sdo` rests at 1.
- R9: The full flag clears only when status bit 0 is written as 0 after a read of address 0 that used `reg_rd`. A write of 0 with no earlier read leaves the flag at 1. Writing 1 to a flag bit never changes it.
- R10: Writing status bit 1 as 0 clears the overrun flag, and the next frame is received and transmitted normally.
- R11: A byte written to address 0 is sent least significant bit first, with `sdo` changing on falling serial clock edges. The transmit-empty flag (status bit 2) goes to 0 on the write and back to 1 when the byte enters the shift register. The transmit path is enabled by control bit 2.
- R12: After reset the status reads 0x04, the received byte reads 0, `sck_out` and `sdo` are 1, `sck_oe` is 0 and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 divider |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks the data register as read) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected address |
| sck_in | input | 1 | External serial clock used in slave mode |
| sck_out | output | 1 | Generated serial clock, rests high |
| sck_oe | output | 1 | Drive enable for the serial clock (1 in master mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, 1 when idle |
| irq_rx | output | 1 | Received-byte interrupt request |
| irq_err | output | 1 | Overrun interrupt request |

## Verification
The hardest state to reach from the ports is a frame that arrives while the overrun flag is set and a transmit byte is waiting. The bench gets there by leaving one received byte unread and clocking in a second frame, which raises the overrun. It then writes a transmit byte and clocks a third frame. That frame must change nothing: the held byte stays, the transmit byte is not taken, and `sdo` reads back as all ones. After the overrun is cleared, a fourth frame checks that both directions resume on the next frame.

// File: rtl/sync_ser_pkg.sv
package sync_ser_pkg;

    localparam int SER_DATA_W   = 8;
    localparam int SER_DIV_W    = 8;
    localparam int SER_SYNC_LEN = 2;

    // bit positions inside the status register
    localparam int STAT_FULL = 0;
    localparam int STAT_OVR  = 1;
    localparam int STAT_TXE  = 2;

    typedef enum logic [1:0] {
        ADR_DATA = 2'd0,
        ADR_STAT = 2'd1,
        ADR_CTRL = 2'd2,
        ADR_DIV  = 2'd3
    } reg_addr_e;

    // control register, bit 0 = master ... bit 3 = irq enable
    typedef struct packed {
        logic irq_en;
        logic tx_en;
        logic rx_en;
        logic master;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

    // shift one new bit in at the top, oldest bit moves toward bit 0
    function automatic logic [SER_DATA_W-1:0] shift_lsb_first(
        input logic [SER_DATA_W-1:0] cur,
        input logic                  bit_in
    );
        return {bit_in, cur[SER_DATA_W-1:1]};
    endfunction

endpackage

// File: rtl/sser_sync.sv
module sser_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[LAST-1:0], d};
    end

    assign q = chain[LAST];
endmodule

// File: rtl/sser_clkgen.sv
module sser_clkgen
    import sync_ser_pkg::*;
#(
    parameter int DIV_W  = SER_DIV_W,
    parameter int BITS   = SER_DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master,
    input  logic             halt,
    input  logic             start_req,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_sync,
    output sck_evt_t         evt,
    output logic             sck_drv
);
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);

    logic             sck_prev;
    logic             run;
    logic             sck_q;
    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] rise_cnt;
    logic             tick;

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b1;
        else     sck_prev <= sck_sync;
    end

    assign tick = master && run && (div_cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !master) begin
            run      <= 1'b0;
            sck_q    <= 1'b1;
            div_cnt  <= '0;
            rise_cnt <= '0;
        end else if (!run) begin
            sck_q    <= 1'b1;
            div_cnt  <= '0;
            rise_cnt <= '0;
            if (start_req && !halt) run <= 1'b1;
        end else if (tick) begin
            div_cnt <= '0;
            sck_q   <= ~sck_q;
            if (!sck_q) begin
                rise_cnt <= rise_cnt + 1'b1;
                if (rise_cnt == LAST_BIT) run <= 1'b0;
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    always_comb begin
        if (master) begin
            evt.rise = tick && !sck_q;
            evt.fall = tick && sck_q;
        end else begin
            evt.rise = sck_sync && !sck_prev;
            evt.fall = !sck_sync && sck_prev;
        end
    end

    assign sck_drv = sck_q;

    // R8: a halted master never starts a new frame
    a_r8_no_start_when_halted: assert property (@(posedge clk) disable iff (rst)
        master && halt && !run |=> !run);

    // R2: the generated clock rests high whenever no frame is running
    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        !run |-> sck_drv);

    // R2: an edge is never rising and falling at once
    a_r2_single_edge: assert property (@(posedge clk) disable iff (rst)
        !(evt.rise && evt.fall));
endmodule

// File: rtl/sser_rx.sv
module sser_rx
    import sync_ser_pkg::*;
#(
    parameter int BITS = SER_DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            halt,
    input  logic            rise,
    input  logic            sdi_s,
    output logic            done,
    output logic [BITS-1:0] data
);
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);

    logic [BITS-1:0]  shreg;
    logic [BITS-1:0]  shnext;
    logic [CNT_W-1:0] cnt;

    assign shnext = shift_lsb_first(shreg, sdi_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
            done  <= 1'b0;
            data  <= '0;
        end else begin
            done <= 1'b0;
            if (!en || halt) begin
                cnt <= '0;
            end else if (rise) begin
                shreg <= shnext;
                if (cnt == LAST_BIT) begin
                    cnt  <= '0;
                    data <= shnext;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1: one completion pulse per frame
    a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: nothing completes while halted
    a_r8_rx_quiet: assert property (@(posedge clk) disable iff (rst)
        halt && $past(halt) |-> !done);
endmodule

// File: rtl/sser_tx.sv
module sser_tx
    import sync_ser_pkg::*;
#(
    parameter int BITS = SER_DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            halt,
    input  logic            rise,
    input  logic            fall,
    input  logic            pend,
    input  logic [BITS-1:0] tdr,
    output logic            load,
    output logic            sdo
);
    localparam int CNT_W = $clog2(BITS);

    logic [BITS-1:0]  shreg;
    logic [CNT_W-1:0] cnt;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '1;
            cnt    <= '0;
            active <= 1'b0;
            load   <= 1'b0;
        end else begin
            load <= 1'b0;
            if (!en || halt) begin
                cnt    <= '0;
                active <= 1'b0;
            end else if (fall) begin
                cnt <= cnt + 1'b1;
                if (cnt == '0) begin
                    if (pend) begin
                        shreg  <= tdr;
                        active <= 1'b1;
                        load   <= 1'b1;
                    end else begin
                        shreg  <= '1;
                        active <= 1'b0;
                    end
                end else begin
                    shreg <= {1'b1, shreg[BITS-1:1]};
                end
            end else if (rise && cnt == '0) begin
                active <= 1'b0;
            end
        end
    end

    assign sdo = active ? shreg[0] : 1'b1;

    // R8: the output line rests at 1 while halted
    a_r8_tx_mark: assert property (@(posedge clk) disable iff (rst)
        halt |=> sdo);

    // R11: a load happens only at the start of a frame
    a_r11_load_at_start: assert property (@(posedge clk) disable iff (rst)
        load |-> cnt == CNT_W'(1));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import sync_ser_pkg::*;
#(
    parameter int DATA_W = SER_DATA_W,
    parameter int DIV_W  = SER_DIV_W,
    parameter int SYNC_N = SER_SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              irq_rx,
    output logic              irq_err
);
    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rdr;
    logic [DATA_W-1:0] tdr;
    logic              rx_full;
    logic              ovr;
    logic              tx_empty;
    logic              rd_seen;
    logic              irq_rx_q;
    logic              irq_err_q;

    logic              sck_s;
    logic              sdi_s;
    sck_evt_t          evt;
    logic              rx_done;
    logic [DATA_W-1:0] rx_byte;
    logic              tx_load;
    logic              start_req;

    reg_addr_e         sel;
    logic              wr_data, wr_stat, wr_ctrl, wr_div, rd_data;
    logic              rx_set, ovr_set, clr_full, clr_ovr;

    assign sel     = reg_addr_e'(reg_addr);
    assign wr_data = reg_wr && sel == ADR_DATA;
    assign wr_stat = reg_wr && sel == ADR_STAT;
    assign wr_ctrl = reg_wr && sel == ADR_CTRL;
    assign wr_div  = reg_wr && sel == ADR_DIV;
    assign rd_data = reg_rd && sel == ADR_DATA;

    assign rx_set   = rx_done && !rx_full;
    assign ovr_set  = rx_done && rx_full;
    assign clr_full = wr_stat && !reg_wdata[STAT_FULL] && rd_seen && rx_full;
    assign clr_ovr  = wr_stat && !reg_wdata[STAT_OVR];

    assign start_req = (ctrl_q.rx_en && !ctrl_q.tx_en) || (ctrl_q.tx_en && !tx_empty);

    sser_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sck_sync (
        .clk(clk), .rst(rst), .d(sck_in), .q(sck_s)
    );

    sser_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sdi_sync (
        .clk(clk), .rst(rst), .d(sdi), .q(sdi_s)
    );

    sser_clkgen #(.DIV_W(DIV_W), .BITS(DATA_W)) u_clkgen (
        .clk(clk), .rst(rst), .master(ctrl_q.master), .halt(ovr),
        .start_req(start_req), .div(div_q), .sck_sync(sck_s),
        .evt(evt), .sck_drv(sck_out)
    );

    sser_rx #(.BITS(DATA_W)) u_rx (
        .clk(clk), .rst(rst), .en(ctrl_q.rx_en), .halt(ovr),
        .rise(evt.rise), .sdi_s(sdi_s), .done(rx_done), .data(rx_byte)
    );

    sser_tx #(.BITS(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .en(ctrl_q.tx_en), .halt(ovr),
        .rise(evt.rise), .fall(evt.fall), .pend(!tx_empty), .tdr(tdr),
        .load(tx_load), .sdo(sdo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            div_q     <= '0;
            rdr       <= '0;
            tdr       <= '0;
            rx_full   <= 1'b0;
            ovr       <= 1'b0;
            tx_empty  <= 1'b1;
            rd_seen   <= 1'b0;
            irq_rx_q  <= 1'b0;
            irq_err_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (wr_div)  div_q  <= reg_wdata[DIV_W-1:0];
            if (wr_data) tdr    <= reg_wdata;

            if (wr_data)      tx_empty <= 1'b0;
            else if (tx_load) tx_empty <= 1'b1;

            if (rx_set) begin
                rdr     <= rx_byte;
                rx_full <= 1'b1;
                rd_seen <= 1'b0;
            end else if (clr_full) begin
                rx_full <= 1'b0;
                rd_seen <= 1'b0;
            end else if (rd_data && rx_full) begin
                rd_seen <= 1'b1;
            end

            if (ovr_set)      ovr <= 1'b1;
            else if (clr_ovr) ovr <= 1'b0;

            if (rx_set && ctrl_q.irq_en)          irq_rx_q <= 1'b1;
            else if (clr_full || !ctrl_q.irq_en)  irq_rx_q <= 1'b0;

            if (ovr_set && ctrl_q.irq_en)         irq_err_q <= 1'b1;
            else if (clr_ovr || !ctrl_q.irq_en)   irq_err_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            ADR_DATA: reg_rdata = rdr;
            ADR_STAT: reg_rdata = DATA_W'({tx_empty, ovr, rx_full});
            ADR_CTRL: reg_rdata = DATA_W'(ctrl_q);
            ADR_DIV:  reg_rdata = DATA_W'(div_q);
        endcase
    end

    assign sck_oe  = ctrl_q.master;
    assign irq_rx  = irq_rx_q;
    assign irq_err = irq_err_q;

    // R4: an empty holding register takes the completed byte and becomes full
    a_r4_load_when_empty: assert property (@(posedge clk) disable iff (rst)
        rx_done && !rx_full |=> rx_full && rdr == $past(rx_byte));

    // R5: a byte completed into a full register raises overrun, data is kept
    a_r5_keep_on_overrun: assert property (@(posedge clk) disable iff (rst)
        rx_done && rx_full |=> ovr && $stable(rdr));

    // R6: a new full flag with irq enable raises the receive request
    a_r6_irq_on_full: assert property (@(posedge clk) disable iff (rst)
        rx_done && !rx_full && ctrl_q.irq_en && !wr_ctrl |=> irq_rx);

    // R7: a new overrun with irq enable raises the error request
    a_r7_irq_on_overrun: assert property (@(posedge clk) disable iff (rst)
        rx_done && rx_full && ctrl_q.irq_en && !wr_ctrl |=> irq_err);

    // R9: writing 0 without a prior data read leaves the full flag set
    a_r9_clear_needs_read: assert property (@(posedge clk) disable iff (rst)
        wr_stat && !rd_seen && rx_full |=> rx_full);
endmodule

// File: tb/sync_serial_xcvr_tb_top.sv
module sync_serial_xcvr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 6;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 6;
    // each entry: {byte clocked in, byte queued for sending}
    localparam logic [15:0] VEC [NVEC] = '{
        16'hA5_3C, 16'h01_80, 16'hFF_00, 16'h00_FF, 16'h96_69, 16'h7E_C3
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe;
    logic       sdi = 1'b1;
    logic       sdo, irq_rx, irq_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_xcvr dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdi(sdi), .sdo(sdo), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // external master clocks one frame in and captures sdo
    task automatic slave_frame(input logic [7:0] b, output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sck_in = 1'b0; sdi = b[i];
            repeat (HALF_BIT) @(negedge clk);
            got[i] = sdo;
            sck_in = 1'b1;
            repeat (HALF_BIT) @(negedge clk);
        end
        repeat (HALF_BIT) @(negedge clk);
    endtask

    // external slave following the generated clock
    task automatic master_frame(input logic [7:0] b, output logic [7:0] got, output int low_len);
        low_len = 0;
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 2000 && sck_out !== 1'b0; k++) @(negedge clk);
            sdi = b[i];
            for (int k = 0; k < 2000 && sck_out !== 1'b1; k++) begin
                @(negedge clk);
                if (i == 0) low_len++;
            end
            got[i] = sdo;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, got;
        int         low;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        peek(2'd1, v); chk("R12 status", v, 8'h04);
        peek(2'd0, v); chk("R12 data", v, 8'h00);
        chk("R12 sck_out", sck_out, 1);
        chk("R12 sdo", sdo, 1);
        chk("R12 sck_oe", sck_oe, 0);
        chk("R12 irqs", {irq_rx, irq_err}, 2'b00);

        // slave mode, rx + tx + irq enable
        host_write(2'd2, 8'h0E);
        chk("R2 slave sck_oe", sck_oe, 0);

        for (int n = 0; n < NVEC; n++) begin
            host_write(2'd0, VEC[n][7:0]);
            peek(2'd1, v); chk("R11 tx_empty cleared by write", v[2], 0);
            slave_frame(VEC[n][15:8], got);
            chk("R11 LSB-first transmit", got, VEC[n][7:0]);
            peek(2'd0, v); chk("R1 R3 received byte", v, VEC[n][15:8]);
            peek(2'd1, v); chk("R4 R11 status after frame", v, 8'h05);
            chk("R6 irq_rx raised", irq_rx, 1);
            host_read(2'd0, v);
            host_write(2'd1, 8'h00);
            peek(2'd1, v); chk("R9 full cleared after read", v[0], 0);
            chk("R6 irq_rx dropped", irq_rx, 0);
        end

        // R6 with irq enable clear
        host_write(2'd2, 8'h06);
        slave_frame(8'h77, got);
        peek(2'd1, v); chk("R4 full without irq", v[0], 1);
        chk("R6 no irq when disabled", irq_rx, 0);
        host_read(2'd0, v); chk("R1 byte 0x77", v, 8'h77);
        host_write(2'd1, 8'h00);

        // overrun sequence
        host_write(2'd2, 8'h0E);
        slave_frame(8'h11, got);
        slave_frame(8'h22, got);
        peek(2'd0, v); chk("R5 data kept on overrun", v, 8'h11);
        peek(2'd1, v); chk("R5 overrun flag", v[1:0], 2'b11);
        chk("R7 irq_err raised", irq_err, 1);

        host_write(2'd0, 8'h5A);
        slave_frame(8'h33, got);
        chk("R8 sdo idle while halted", got, 8'hFF);
        peek(2'd1, v); chk("R8 tx byte not taken", v, 8'h03);
        peek(2'd0, v); chk("R8 frame ignored", v, 8'h11);

        host_write(2'd1, 8'h01);
        peek(2'd1, v); chk("R10 overrun cleared, R9 write 1 keeps full", v[1:0], 2'b01);
        chk("R7 irq_err dropped", irq_err, 0);
        host_write(2'd1, 8'h00);
        peek(2'd1, v); chk("R9 clear without read ignored", v[0], 1);
        host_read(2'd0, v);
        host_write(2'd1, 8'h00);
        peek(2'd1, v); chk("R9 cleared after read", v[0], 0);

        slave_frame(8'h44, got);
        chk("R10 tx resumes", got, 8'h5A);
        peek(2'd0, v); chk("R10 rx resumes", v, 8'h44);
        host_read(2'd0, v);
        host_write(2'd1, 8'h00);

        // master mode, simultaneous transfer
        host_write(2'd3, 8'h05);
        host_write(2'd2, 8'h0F);
        chk("R2 master sck_oe", sck_oe, 1);
        repeat (20) @(negedge clk);
        chk("R2 idle high without data", sck_out, 1);
        host_write(2'd0, 8'hA5);
        master_frame(8'h3C, got, low);
        chk("R2 half period = div+1", low, 6);
        chk("R11 master transmit", got, 8'hA5);
        repeat (20) @(negedge clk);
        chk("R2 clock stops after frame", sck_out, 1);
        peek(2'd0, v); chk("R1 master receive", v, 8'h3C);
        peek(2'd1, v); chk("R11 tx_empty after load", v, 8'h05);
        chk("R6 irq_rx master", irq_rx, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule